// File: doc/BRIEF.md
# Program Flow Trace Status Generator

This block sits next to a processor fetch unit and produces what an external debug system needs to rebuild the program flow. Every clock it reports a registered 3-bit status code. The code describes the fetch seen in the previous cycle. Next to it is a saturated count of the instructions cancelled in that cycle. For each accepted fetch the block also decides two things. The first is whether the fetch carries the trace-cycle attribute. The second is whether it must be forced onto the external bus, even when its data sits in an internal memory.

A fetch gets the trace-cycle attribute when program flow changes in a way that cannot be predicted from the code alone. This covers three cases: a taken branch whose target comes from the link or count register, an exception, and a fetch that follows a context-switching instruction (return from interrupt, a machine-state write or a special-register write). An upstream classifier marks that last case.

A sync request bit comes from the serial debug port. While it is set, every tagged fetch is forced visible. Setting it starts a resynchronisation, and clearing it starts another. The first fetch after either change is tagged and forced visible. A control field can force visibility independently of the sync request.

Top module: `flow_trace_status`

## Requirements
- R1: While `rst_n` is low, the outputs become status 000, cancel count 0, tag 0 and force 0 at the next clock edge. Any pending resynchronisation is discarded, and a sync request held steady through reset starts no new one.
- R2: The status and the other outputs appear one clock after the fetch they describe. `fetch_kind` 00 (sequential) gives 001. 01 (branch not taken) gives 010. 10 (direct branch taken) gives 011. 11 (taken branch with a register target) gives 100. A cycle with `fetch_vld` low gives 000 (stall), whatever the other fetch inputs are.
- R3: With `fetch_vld` high, `exc_taken` gives status 101 and overrides `fetch_kind` and `ctx_switch`. The codes 110 and 111 are never emitted.
- R4: An accepted fetch with `ctx_switch` high and `exc_taken` low reports 100, whatever `fetch_kind` is.
- R5: An accepted fetch is tagged (`trace_cycle`) when it is an exception, a register-target branch or a context-switch fetch. Sequential, not-taken and direct-taken fetches are not tagged unless R8 applies.
- R6: `cancel_cnt` reports the `cancel_in` value of the previous clock, saturated at 3.
- R7: While `sync_req` is high, every tagged fetch is forced visible. With `show_mode` 00, untagged fetches are not forced.
- R8: A rising or a falling edge of `sync_req` arms a resynchronisation. The next accepted fetch is then tagged and forced visible, and doing so clears the resynchronisation. Stall cycles leave it armed, and only that one fetch is affected.
- R9: `show_mode` 01 forces every tagged fetch visible, whatever the value of `sync_req`.
- R10: `show_mode` 10 or 11 forces every accepted fetch visible. A stall cycle is never tagged or forced.
- R11: A fetch accepted in the same cycle as a `sync_req` edge consumes that resynchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_vld | input | 1 | A fetch is accepted this cycle |
| fetch_kind | input | 2 | Flow type of the fetch: 00 seq, 01 not taken, 10 direct taken, 11 register-target taken |
| exc_taken | input | 1 | The fetch is an exception vector fetch |
| ctx_switch | input | 1 | The fetch follows a context-switching instruction |
| cancel_in | input | CIN_W | Instructions cancelled this cycle |
| sync_req | input | 1 | Sync request bit from the serial debug port |
| show_mode | input | 2 | Show-cycle control: 00 off, 01 tagged fetches, 1x all fetches |
| trace_stat | output | 3 | Status of the last fetched instruction |
| cancel_cnt | output | 2 | Saturated cancel count |
| trace_cycle | output | 1 | The fetch carries the trace-cycle attribute |
| force_vis | output | 1 | The fetch must be shown on the external bus |

## Verification
The hardest case to reach is an armed resynchronisation that has to survive stall cycles. The bench raises `sync_req` while no fetch is accepted, holds the stall for two cycles, and then shows that only the first fetch after the stall is tagged.

The falling edge is checked while a fetch is accepted in the same cycle, to confirm that this fetch consumes it. Reset is then applied with a resynchronisation armed and `sync_req` held high, to confirm that nothing survives the reset.

// File: rtl/fts_pkg.sv
// Package: shared encodings for the flow trace status generator.
// Assumes: status codes 110/111 are reserved and never produced.
package fts_pkg;
    typedef enum logic [2:0] {
        ST_STALL = 3'b000,
        ST_SEQ   = 3'b001,
        ST_NT    = 3'b010,
        ST_DIR   = 3'b011,
        ST_IND   = 3'b100,
        ST_EXC   = 3'b101
    } trc_stat_e;

    typedef enum logic [1:0] {
        FK_SEQ = 2'b00,
        FK_NT  = 2'b01,
        FK_DIR = 2'b10,
        FK_REG = 2'b11
    } fetch_kind_e;

    localparam int STAT_W = 3;
    localparam int SHOW_W = 2;
endpackage

// File: rtl/fts_classify.sv
// Module: fts_classify
// Purpose: maps one cycle of fetch indications to a status code and decides
// whether the fetch is an indirect flow change.
// Assumes: exception outranks a context switch, which outranks fetch_kind.
module fts_classify
    import fts_pkg::*;
(
    input  logic        fetch_vld,
    input  fetch_kind_e fetch_kind,
    input  logic        exc_taken,
    input  logic        ctx_switch,
    output trc_stat_e   stat,
    output logic        indirect
);
    // Status selection by priority.
    always_comb begin
        if (!fetch_vld) begin
            stat = ST_STALL;
        end else if (exc_taken) begin
            stat = ST_EXC;
        end else if (ctx_switch) begin
            stat = ST_IND;
        end else begin
            case (fetch_kind)
                FK_SEQ:  stat = ST_SEQ;
                FK_NT:   stat = ST_NT;
                FK_DIR:  stat = ST_DIR;
                default: stat = ST_IND;
            endcase
        end
    end

    // Indirect flow change: target not derivable from the code image.
    always_comb begin
        indirect = fetch_vld & (exc_taken | ctx_switch | (fetch_kind == FK_REG));
    end
endmodule

// File: rtl/fts_resync.sv
// Module: fts_resync
// Purpose: arms a resynchronisation on each edge of the sync request and
// releases it on the next accepted fetch.
// Assumes: during reset the sync history follows the input, so a level held
// through reset is not seen as an edge.
module fts_resync (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    input  logic fetch_vld,
    output logic resync_hit
);
    logic sync_q;
    logic pend_q;
    logic edge_now;

    // Edge of the sync request against last cycle.
    always_comb begin
        edge_now = sync_req ^ sync_q;
    end

    // Current fetch consumes an armed or newly armed resynchronisation.
    always_comb begin
        resync_hit = fetch_vld & (pend_q | edge_now);
    end

    // Sync history and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= sync_req;
            pend_q <= 1'b0;
        end else begin
            sync_q <= sync_req;
            pend_q <= (pend_q | edge_now) & ~fetch_vld;
        end
    end
endmodule

// File: rtl/fts_cancel_sat.sv
// Module: fts_cancel_sat
// Purpose: narrows the raw cancel count to the output width, saturating.
// Assumes: the input is an unsigned count.
module fts_cancel_sat #(
    parameter int IN_W  = 3,
    parameter int OUT_W = 2
) (
    input  logic [IN_W-1:0]  raw,
    output logic [OUT_W-1:0] sat
);
    localparam int unsigned MAXV = (1 << OUT_W) - 1;

    generate
        if (IN_W <= OUT_W) begin : g_pass
            // Input always fits: zero-extend.
            always_comb begin
                sat = OUT_W'(raw);
            end
        end else begin : g_clip
            // Clip anything above the output range.
            always_comb begin
                if (raw > IN_W'(MAXV)) sat = OUT_W'(MAXV);
                else                   sat = raw[OUT_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/flow_trace_status.sv
// Module: flow_trace_status (top)
// Purpose: registered trace status, cancel count, trace-cycle tag and forced
// bus visibility for each fetch.
// Assumes: one fetch at most per cycle; outputs describe the previous cycle.
module flow_trace_status
    import fts_pkg::*;
#(
    parameter int CIN_W = 3,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_vld,
    input  logic [1:0]       fetch_kind,
    input  logic             exc_taken,
    input  logic             ctx_switch,
    input  logic [CIN_W-1:0] cancel_in,
    input  logic             sync_req,
    input  logic [1:0]       show_mode,
    output logic [2:0]       trace_stat,
    output logic [CNT_W-1:0] cancel_cnt,
    output logic             trace_cycle,
    output logic             force_vis
);
    trc_stat_e        stat_c;
    logic             indirect_c;
    logic             resync_c;
    logic [CNT_W-1:0] cnt_c;
    logic             tag_c;
    logic             force_c;

    fts_classify u_cls (
        .fetch_vld (fetch_vld),
        .fetch_kind(fetch_kind_e'(fetch_kind)),
        .exc_taken (exc_taken),
        .ctx_switch(ctx_switch),
        .stat      (stat_c),
        .indirect  (indirect_c)
    );

    fts_resync u_rsy (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_req  (sync_req),
        .fetch_vld (fetch_vld),
        .resync_hit(resync_c)
    );

    fts_cancel_sat #(.IN_W(CIN_W), .OUT_W(CNT_W)) u_sat (
        .raw(cancel_in),
        .sat(cnt_c)
    );

    // Tag and visibility decision for this cycle's fetch.
    always_comb begin
        tag_c   = indirect_c | resync_c;
        force_c = resync_c
                | (tag_c & (sync_req | show_mode[0]))
                | (fetch_vld & show_mode[1]);
    end

    // Output registers aligned with the described fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_stat  <= ST_STALL;
            cancel_cnt  <= '0;
            trace_cycle <= 1'b0;
            force_vis   <= 1'b0;
        end else begin
            trace_stat  <= stat_c;
            cancel_cnt  <= cnt_c;
            trace_cycle <= tag_c;
            force_vis   <= force_c;
        end
    end
endmodule

// File: rtl/flow_trace_status_chk.sv
// Module: flow_trace_status_chk
// Purpose: temporal checks on the ports of flow_trace_status, bound below.
module flow_trace_status_chk #(
    parameter int CIN_W = 3,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_vld,
    input logic [1:0]       fetch_kind,
    input logic             exc_taken,
    input logic             ctx_switch,
    input logic [CIN_W-1:0] cancel_in,
    input logic             sync_req,
    input logic [1:0]       show_mode,
    input logic [2:0]       trace_stat,
    input logic [CNT_W-1:0] cancel_cnt,
    input logic             trace_cycle,
    input logic             force_vis
);
    localparam int unsigned SATV = (1 << CNT_W) - 1;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (trace_stat == 3'b000 && !trace_cycle && !force_vis));

    // R3
    no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |=> (trace_stat < 3'd6));

    // R3
    exc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && exc_taken) |=> (trace_stat == 3'b101 && trace_cycle));

    // R10
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> (trace_stat == 3'b000 && !trace_cycle && !force_vis));

    // R6
    cancel_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cancel_in) >= SATV) |=> (32'(cancel_cnt) == SATV));

    // R8
    rise_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_req) && fetch_vld) |=> (trace_cycle && force_vis));

    // R8
    fall_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_req) && fetch_vld) |=> (trace_cycle && force_vis));

    // R7
    sync_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> (!trace_cycle || force_vis));

    // R10
    show_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && show_mode[1]) |=> force_vis);
endmodule

bind flow_trace_status flow_trace_status_chk #(.CIN_W(CIN_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_vld  (fetch_vld),
    .fetch_kind (fetch_kind),
    .exc_taken  (exc_taken),
    .ctx_switch (ctx_switch),
    .cancel_in  (cancel_in),
    .sync_req   (sync_req),
    .show_mode  (show_mode),
    .trace_stat (trace_stat),
    .cancel_cnt (cancel_cnt),
    .trace_cycle(trace_cycle),
    .force_vis  (force_vis)
);

// File: tb/tb_flow_trace_status.sv
// Bench: vector table walk, then directed reset and corner cases.
module tb_flow_trace_status;
    localparam int NV = 20;
    // {vld, kind[2], exc, ctx, cancel[3], sync, show[2]} , {stat[3], cnt[2], tag, force}
    localparam logic [17:0] VEC [NV] = '{
        18'b1_00_0_0_000_0_00_001_00_0_0, // 0  R2 seq
        18'b1_01_0_0_001_0_00_010_01_0_0, // 1  R2 not taken
        18'b1_10_0_0_010_0_00_011_10_0_0, // 2  R2 direct
        18'b1_11_0_0_011_0_00_100_11_1_0, // 3  R5 register target
        18'b1_00_1_0_111_0_00_101_11_1_0, // 4  R3 R6 exception, saturate
        18'b1_10_0_1_101_0_00_100_11_1_0, // 5  R4 context switch
        18'b0_11_1_0_000_0_00_000_00_0_0, // 6  R2 stall ignores fetch inputs
        18'b0_00_0_0_000_1_00_000_00_0_0, // 7  R8 rise while stalled
        18'b0_00_0_0_000_1_00_000_00_0_0, // 8  R8 still armed
        18'b1_00_0_0_000_1_00_001_00_1_1, // 9  R8 first fetch consumes
        18'b1_00_0_0_000_1_00_001_00_0_0, // 10 R7 untagged not forced
        18'b1_11_0_0_000_1_00_100_00_1_1, // 11 R7 tagged forced
        18'b1_00_0_0_000_0_00_001_00_1_1, // 12 R11 fall with fetch
        18'b1_00_0_0_000_0_00_001_00_0_0, // 13 R8 only one fetch
        18'b1_11_0_0_000_0_01_100_00_1_1, // 14 R9
        18'b1_00_0_0_000_0_01_001_00_0_0, // 15 R9 untagged
        18'b1_00_0_0_000_0_10_001_00_0_1, // 16 R10 all fetches
        18'b0_00_0_0_000_0_11_000_00_0_0, // 17 R10 stall never shown
        18'b1_01_0_0_000_0_11_010_00_0_1, // 18 R10
        18'b1_00_1_0_000_0_00_101_00_1_0  // 19 R3 R5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_vld = 1'b0;
    logic [1:0] fetch_kind = 2'b00;
    logic       exc_taken = 1'b0;
    logic       ctx_switch = 1'b0;
    logic [2:0] cancel_in = 3'd0;
    logic       sync_req = 1'b0;
    logic [1:0] show_mode = 2'b00;
    logic [2:0] trace_stat;
    logic [1:0] cancel_cnt;
    logic       trace_cycle;
    logic       force_vis;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flow_trace_status dut (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_kind(fetch_kind),
        .exc_taken(exc_taken), .ctx_switch(ctx_switch), .cancel_in(cancel_in),
        .sync_req(sync_req), .show_mode(show_mode), .trace_stat(trace_stat),
        .cancel_cnt(cancel_cnt), .trace_cycle(trace_cycle), .force_vis(force_vis)
    );

    function automatic string vreq(int i);
        case (i)
            0, 1, 2, 6: return "R2";
            3:          return "R5";
            4, 19:      return "R3";
            5:          return "R4";
            7, 8, 9, 13: return "R8";
            10, 11:     return "R7";
            12:         return "R11";
            14, 15:     return "R9";
            default:    return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [6:0] exp);
        logic [6:0] got;
        got = {trace_stat, cancel_cnt, trace_cycle, force_vis};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s stat/cnt/tag/force got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(logic [10:0] s);
        {fetch_vld, fetch_kind, exc_taken, ctx_switch, cancel_in, sync_req, show_mode} = s;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 7'b000_00_0_0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][17:7]);
            @(negedge clk);
            check(vreq(i), VEC[i][6:0]);
        end
        // Directed R6: counts below saturation pass through.
        drive(11'b0_00_0_0_010_0_00);
        @(negedge clk);
        check("R6", 7'b000_10_0_0);
        // Directed R1: armed resync and held sync_req across reset.
        drive(11'b0_00_0_0_000_1_00);
        @(negedge clk);
        rst_n = 1'b0;
        drive(11'b1_11_1_0_111_1_11);
        @(negedge clk);
        check("R1", 7'b000_00_0_0);
        drive(11'b0_00_0_0_000_1_00);
        @(negedge clk);
        rst_n = 1'b1;
        drive(11'b1_00_0_0_000_1_00);
        @(negedge clk);
        check("R1", 7'b001_00_0_0);
        // Directed R8: falling edge while stalled, then fetch.
        drive(11'b0_00_0_0_000_0_00);
        @(negedge clk);
        check("R8", 7'b000_00_0_0);
        drive(11'b1_01_0_0_000_0_00);
        @(negedge clk);
        check("R8", 7'b010_00_1_1);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule